// File: doc/BRIEF.md
# Pulse-Count Brightness Programming Interface

This block turns a two-wire host command into a brightness setting for a backlight boost converter. The host pulls an active-low select line down and then sends clock pulses. A single marker bit travels one stage along a chain of `STAGES` flops for each counted pulse. When select is released, the stage that holds the marker becomes the latched brightness level. If the host sends more pulses than there are stages, the marker drops off the end. The latched level is then zero and the converter shuts down. No error is reported in that case.

A mode input chooses between this remote programming and a local mode. In local mode the serial clock is ignored and the select line only switches the output on or off at a fixed base current. Every input passes through a two-flop synchronizer and an edge detector that run on a system clock at least four times faster than the fastest serial clock. The block drives four outputs: the latched level, a current-multiplier code in half-units for the analog mirror, a converter enable, and a settled flag. The settled flag rises only after a parameterized stabilization delay has elapsed.

Top module: `pulse_dimmer_ctrl`

## Requirements
- R1: A synchronized falling edge of `sel_n_i` in remote mode discards any chain content and arms a new marker. A release with no pulses latches level 0, and a release after n pulses latches n no matter what was programmed before.
- R2: While select stays low in remote mode, each synchronized rising edge of `sck_i` advances the marker by one stage. After n pulses (1 <= n <= STAGES) the level latched on release is n, and at most one chain bit is ever set.
- R3: `level_o` changes only on a synchronized rising edge of `sel_n_i` in remote mode. While select is low the previous level is still shown. The chain is empty after every release.
- R4: If more than STAGES pulses are counted, the release latches level 0 and `conv_en_o` stays low.
- R5: In remote mode `mult_o` equals 2*level+1 (the multiplier level+0.5 expressed in half-units), and 0 when the level is 0.
- R6: `conv_en_o` is high exactly when `mult_o` is nonzero. `settled_o` rises after SETTLE_CYCLES+1 cycles of unchanged, enabled output. It is cleared by every release that latches a nonzero level, including one that latches the same value again.
- R7: With `remote_i` low, `sck_i` is ignored. Select low gives `mult_o` = 2 (base current) with the converter enabled, and select high gives `mult_o` = 0. The latched level is left untouched.
- R8: After reset `level_o`, `mult_o`, `conv_en_o` and `settled_o` are 0. The synchronizers start as if select is high (idle) and mode is high (remote).
- R9: A serial clock rising edge that shows up after synchronization in the same cycle as a select edge, either falling or rising, is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Host select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous |
| remote_i | input | 1 | Mode: 1 = pulse programming, 0 = local on/off |
| level_o | output | $clog2(STAGES+1) | Latched brightness level, 0 = off |
| mult_o | output | $clog2(STAGES+1)+1 | Current multiplier in half-units |
| conv_en_o | output | 1 | Boost converter enable |
| settled_o | output | 1 | Output current has had time to stabilize |

## Verification
The serial clock edge and a select edge can reach the synchronized domain in the same system cycle. One case is a final pulse racing the release. The other is a pulse that arrives together with the selecting edge. The bench provokes both by changing `sck_i` and `sel_n_i` at the same instant, so both pass through identical synchronizer depth. It then expects the latched level to count only the pulses that completed strictly inside the select window. A behavioural model counts pulses as integers, follows the settle timer, and is compared with every output on every clock.

// File: rtl/dim_pkg.sv
package dim_pkg;

    // Control mode seen on the synchronized mode input.
    typedef enum logic {
        MODE_LOCAL  = 1'b0,
        MODE_REMOTE = 1'b1
    } ctl_mode_e;

    // One synchronized input: settled level plus single-cycle edge strobes.
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } sync_sig_t;

    // Channel positions on the synchronizer bus.
    localparam int unsigned CH_SEL  = 0;
    localparam int unsigned CH_SCK  = 1;
    localparam int unsigned CH_MODE = 2;
    localparam int unsigned CH_NUM  = 3;

    // Idle value of each channel: select high, clock low, mode high.
    localparam logic [CH_NUM-1:0] CH_IDLE = 3'b101;

    // Base current in local mode, in half-units (1.0).
    localparam int unsigned LOCAL_HALF_UNITS = 2;

    // Multiplier (stage + 0.5) in half-units; zero stage means off.
    function automatic int unsigned stage_half_units(int unsigned stage);
        if (stage == 0) begin
            return 0;
        end
        return 2 * stage + 1;
    endfunction

endpackage

// File: rtl/dim_sync_edge.sv
module dim_sync_edge #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                raw_i,
    output dim_pkg::sync_sig_t  sig_o
);

    // [0] and [1] form the synchronizer, [2] holds the previous level.
    logic [2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= {3{IDLE_VAL}};
        end else begin
            pipe_q <= {pipe_q[1:0], raw_i};
        end
    end

    always_comb begin
        sig_o.lvl  = pipe_q[1];
        sig_o.rise = pipe_q[1] & ~pipe_q[2];
        sig_o.fall = ~pipe_q[1] & pipe_q[2];
    end

endmodule

// File: rtl/dim_marker_chain.sv
module dim_marker_chain #(
    parameter int unsigned STAGES = 7,
    parameter int unsigned LVL_W  = $clog2(STAGES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                remote_i,
    input  dim_pkg::sync_sig_t  sel_i,
    input  dim_pkg::sync_sig_t  sck_i,
    output logic                load_o,
    output logic [LVL_W-1:0]    load_lvl_o
);

    logic [STAGES-1:0] chain_q;
    logic              seed_q;
    logic              count_ok;

    // A clock edge counts only when select was low both before and now,
    // so edges coinciding with either select edge are dropped.
    assign count_ok = remote_i & ~sel_i.lvl & ~sel_i.fall & sck_i.rise;
    assign load_o   = remote_i & sel_i.rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            seed_q  <= 1'b0;
        end else if (remote_i && sel_i.fall) begin
            chain_q <= '0;
            seed_q  <= 1'b1;
        end else if (load_o) begin
            chain_q <= '0;
            seed_q  <= 1'b0;
        end else if (count_ok) begin
            chain_q <= {chain_q[STAGES-2:0], seed_q};
            seed_q  <= 1'b0;
        end
    end

    // Position of the marker, 1-based; empty chain gives 0.
    always_comb begin
        load_lvl_o = '0;
        for (int i = 0; i < STAGES; i++) begin
            if (chain_q[i]) begin
                load_lvl_o = LVL_W'(i + 1);
            end
        end
    end

    AST_MARKER_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chain_q, seed_q})); // R2

    AST_SELECT_ARMS: assert property (@(posedge clk) disable iff (rst)
        (remote_i && sel_i.fall) |=> (seed_q && chain_q == '0)); // R1

    AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        load_o |=> ({chain_q, seed_q} == '0)); // R3

    AST_PULSE_ENTERS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (count_ok && seed_q) |=> chain_q[0]); // R2

    AST_NO_OVERFLOW_RESIDUE: assert property (@(posedge clk) disable iff (rst)
        (count_ok && chain_q[STAGES-1]) |=> (chain_q == '0)); // R4

    AST_EDGE_WITH_SELECT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (remote_i && sel_i.rise && sck_i.rise) |=> (chain_q == '0)); // R9

endmodule

// File: rtl/dim_level_hold.sv
module dim_level_hold #(
    parameter int unsigned STAGES        = 7,
    parameter int unsigned SETTLE_CYCLES = 1000,
    parameter int unsigned LVL_W         = $clog2(STAGES + 1),
    parameter int unsigned MULT_W        = LVL_W + 1,
    parameter int unsigned CNT_W         = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               remote_i,
    input  logic               sel_lvl_i,
    input  logic               load_i,
    input  logic [LVL_W-1:0]   load_lvl_i,
    output logic [LVL_W-1:0]   level_o,
    output logic [MULT_W-1:0]  mult_o,
    output logic               conv_en_o,
    output logic               settled_o
);

    logic [LVL_W-1:0]  level_q;
    logic [MULT_W-1:0] mult_prev_q;
    logic [CNT_W-1:0]  wait_q;
    logic              new_nonzero;
    logic              restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (load_i) begin
            level_q <= load_lvl_i;
        end
    end

    always_comb begin
        if (remote_i) begin
            mult_o = MULT_W'(dim_pkg::stage_half_units(int'(level_q)));
        end else if (!sel_lvl_i) begin
            mult_o = MULT_W'(dim_pkg::LOCAL_HALF_UNITS);
        end else begin
            mult_o = '0;
        end
    end

    assign level_o     = level_q;
    assign conv_en_o   = (mult_o != '0);
    assign new_nonzero = load_i && (load_lvl_i != '0);
    assign restart     = !conv_en_o || new_nonzero || (mult_o != mult_prev_q);

    // Stabilization timer: restarts on any change of the requested current.
    always_ff @(posedge clk) begin
        if (rst) begin
            mult_prev_q <= '0;
            wait_q      <= '0;
        end else begin
            mult_prev_q <= mult_o;
            if (restart) begin
                wait_q <= '0;
            end else if (wait_q != CNT_W'(SETTLE_CYCLES)) begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    assign settled_o = conv_en_o && (wait_q == CNT_W'(SETTLE_CYCLES));

    AST_SETTLED_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        settled_o |-> conv_en_o); // R6

    AST_RELATCH_UNSETTLES: assert property (@(posedge clk) disable iff (rst)
        (SETTLE_CYCLES > 0 && new_nonzero) |=> !settled_o); // R6

    AST_LOCAL_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !remote_i |=> $stable(level_q)); // R7

    AST_ZERO_LEVEL_OFF: assert property (@(posedge clk) disable iff (rst)
        (remote_i && level_q == '0) |-> !conv_en_o); // R4

endmodule

// File: rtl/pulse_dimmer_ctrl.sv
module pulse_dimmer_ctrl #(
    parameter int unsigned STAGES        = 7,
    parameter int unsigned SETTLE_CYCLES = 10_000_000
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           sel_n_i,
    input  logic                           sck_i,
    input  logic                           remote_i,
    output logic [$clog2(STAGES+1)-1:0]    level_o,
    output logic [$clog2(STAGES+1):0]      mult_o,
    output logic                           conv_en_o,
    output logic                           settled_o
);

    import dim_pkg::*;

    localparam int unsigned LVL_W  = $clog2(STAGES + 1);
    localparam int unsigned MULT_W = LVL_W + 1;
    localparam int unsigned CNT_W  = $clog2(SETTLE_CYCLES + 1);

    logic [CH_NUM-1:0] raw_bus;
    sync_sig_t         sig [CH_NUM];
    ctl_mode_e         mode;
    logic              remote;
    logic              load;
    logic [LVL_W-1:0]  load_lvl;
    logic              unused_edges;

    assign raw_bus[CH_SEL]  = sel_n_i;
    assign raw_bus[CH_SCK]  = sck_i;
    assign raw_bus[CH_MODE] = remote_i;

    for (genvar g = 0; g < CH_NUM; g++) begin : g_sync
        dim_sync_edge #(
            .IDLE_VAL(CH_IDLE[g])
        ) u_sync (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_bus[g]),
            .sig_o (sig[g])
        );
    end

    assign mode         = ctl_mode_e'(sig[CH_MODE].lvl);
    assign remote       = (mode == MODE_REMOTE);
    assign unused_edges = ^{sig[CH_SCK].lvl, sig[CH_SCK].fall,
                            sig[CH_MODE].rise, sig[CH_MODE].fall};

    dim_marker_chain #(
        .STAGES (STAGES),
        .LVL_W  (LVL_W)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .remote_i   (remote),
        .sel_i      (sig[CH_SEL]),
        .sck_i      (sig[CH_SCK]),
        .load_o     (load),
        .load_lvl_o (load_lvl)
    );

    dim_level_hold #(
        .STAGES        (STAGES),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .LVL_W         (LVL_W),
        .MULT_W        (MULT_W),
        .CNT_W         (CNT_W)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .remote_i   (remote),
        .sel_lvl_i  (sig[CH_SEL].lvl),
        .load_i     (load),
        .load_lvl_i (load_lvl),
        .level_o    (level_o),
        .mult_o     (mult_o),
        .conv_en_o  (conv_en_o),
        .settled_o  (settled_o)
    );

endmodule

// File: tb/test_pulse_dimmer_ctrl.sv
module test_pulse_dimmer_ctrl;

    localparam int STAGES = 7;
    localparam int SETTLE = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       sck = 1'b0;
    logic       remote = 1'b1;
    logic [2:0] level;
    logic [3:0] mult;
    logic       conv_en;
    logic       settled;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pulse_dimmer_ctrl #(.STAGES(STAGES), .SETTLE_CYCLES(SETTLE)) i_pulse_dimmer_ctrl (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sck_i(sck), .remote_i(remote),
        .level_o(level), .mult_o(mult), .conv_en_o(conv_en), .settled_o(settled)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int hs[$];
    int hk[$];
    int hm[$];
    int pulses = -1;
    int lvl_m  = 0;
    int cnt_m  = 0;
    int mprev  = 0;

    function automatic int f_mult(int lv, int md, int cs);
        if (md != 0) return (lv == 0) ? 0 : 2 * lv + 1;
        return (cs == 0) ? 2 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hs = '{1, 1, 1};
            hk = '{0, 0, 0};
            hm = '{1, 1, 1};
            pulses = -1; lvl_m = 0; cnt_m = 0; mprev = 0;
        end else begin
            int c, cp, k, kp, md, mnow, nl;
            bit load, lnz;
            c = hs[1]; cp = hs[2]; k = hk[1]; kp = hk[2]; md = hm[1];
            mnow = f_mult(lvl_m, md, c);
            load = 1'b0; lnz = 1'b0; nl = 0;
            if (md != 0) begin
                if (cp == 1 && c == 0) begin
                    pulses = 0;
                end else if (cp == 0 && c == 1) begin
                    nl = (pulses >= 1 && pulses <= STAGES) ? pulses : 0;
                    load = 1'b1; lnz = (nl != 0); pulses = -1;
                end else if (c == 0 && k == 1 && kp == 0 && pulses >= 0 && pulses <= STAGES) begin
                    pulses++;
                end
            end
            if (mnow == 0 || lnz || mnow != mprev) cnt_m = 0;
            else if (cnt_m < SETTLE) cnt_m++;
            mprev = mnow;
            if (load) lvl_m = nl;
            hs.push_front(int'(sel_n));  void'(hs.pop_back());
            hk.push_front(int'(sck));    void'(hk.pop_back());
            hm.push_front(int'(remote)); void'(hm.pop_back());
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done && hs.size() == 3) begin
            int em;
            em = f_mult(lvl_m, hm[1], hs[1]);
            chk("R3 level per cycle", int'(level), lvl_m);
            chk("R5 mult per cycle", int'(mult), em);
            chk("R6 enable per cycle", int'(conv_en), int'(em != 0));
            chk("R6 settled per cycle", int'(settled), int'(em != 0 && cnt_m == SETTLE));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        sck = 1'b1; wait_n(3);
        sck = 1'b0; wait_n(3);
    endtask

    task automatic send(int n);
        sel_n = 1'b0; wait_n(4);
        for (int i = 0; i < n; i++) pulse();
        sel_n = 1'b1; wait_n(6);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        chk("R8 reset level", int'(level), 0);
        chk("R8 reset mult", int'(mult), 0);
        chk("R8 reset enable", int'(conv_en), 0);
        chk("R8 reset settled", int'(settled), 0);

        send(3);
        chk("R2 three pulses", int'(level), 3);
        chk("R5 mult for 3", int'(mult), 7);
        chk("R6 enable on", int'(conv_en), 1);
        chk("R6 not yet settled", int'(settled), 0);
        wait_n(SETTLE + 5);
        chk("R6 settled after delay", int'(settled), 1);

        send(7);
        chk("R2 top stage", int'(level), 7);
        chk("R5 mult for 7", int'(mult), 15);

        sel_n = 1'b0; wait_n(4);
        pulse(); pulse();
        chk("R3 level held while selected", int'(level), 7);
        sel_n = 1'b1; wait_n(6);
        chk("R1 new count replaces old", int'(level), 2);

        send(8);
        chk("R4 overflow level", int'(level), 0);
        chk("R4 overflow disables", int'(conv_en), 0);
        chk("R5 mult zero", int'(mult), 0);

        send(1);
        chk("R5 mult for 1", int'(mult), 3);
        send(0);
        chk("R1 no pulses gives zero", int'(level), 0);

        // Final clock edge together with release: not counted.
        sel_n = 1'b0; wait_n(4);
        for (int i = 0; i < 4; i++) pulse();
        sck = 1'b1; sel_n = 1'b1; wait_n(3);
        sck = 1'b0; wait_n(5);
        chk("R9 edge at release ignored", int'(level), 4);

        // Clock edge together with select: not counted.
        sck = 1'b1; sel_n = 1'b0; wait_n(3);
        sck = 1'b0; wait_n(3);
        pulse(); pulse();
        sel_n = 1'b1; wait_n(6);
        chk("R9 edge at select ignored", int'(level), 2);

        send(4);
        wait_n(SETTLE + 5);
        chk("R6 settled before relatch", int'(settled), 1);
        send(4);
        chk("R6 same-value relatch restarts", int'(settled), 0);
        wait_n(SETTLE + 5);
        chk("R6 settled again", int'(settled), 1);

        remote = 1'b0; wait_n(5);
        chk("R7 local off mult", int'(mult), 0);
        chk("R7 local off enable", int'(conv_en), 0);
        chk("R7 level retained", int'(level), 4);
        sel_n = 1'b0; wait_n(5);
        chk("R7 local on mult", int'(mult), 2);
        chk("R7 local on enable", int'(conv_en), 1);
        pulse(); pulse(); pulse();
        chk("R7 clock ignored", int'(level), 4);
        chk("R7 mult unchanged by clock", int'(mult), 2);
        sel_n = 1'b1; wait_n(5);
        chk("R7 local off again", int'(conv_en), 0);
        remote = 1'b1; wait_n(5);
        chk("R7 remote level back", int'(mult), 9);

        send(12);
        chk("R4 long burst", int'(level), 0);

        wait_n(4);
        finish_run();
    end

endmodule